// File: doc/BRIEF.md
# Extended-Accumulator Subtract-With-Borrow Unit

This unit performs one step of a multi-word subtraction on a 36-bit accumulator that carries four guard bits above a 32-bit word. On each execute strobe it subtracts a 32-bit source operand, widened to 36 bits by sign extension, and the incoming carry (borrow) bit from the accumulator value presented at its input. It registers the 36-bit result together with a fresh set of seven condition flags.

The result always wraps modulo 2^36 and is never saturated. The flags report five things: borrow out of the top bit, signed overflow, zero, negative, and whether the guard bits hold more than sign extension. They also report whether the result is unnormalized, and a sticky limit flag that collects every overflow until it is explicitly cleared. Chaining several of these steps, each fed with the previous carry flag, gives subtraction of operands wider than 32 bits.

Top module: `acc_sub_borrow`

## Requirements
- R1: When `exec` is high at a rising edge, `acc_q` becomes `acc_in` minus the sign-extended `src` minus `flags_in[0]` (the incoming carry), taken modulo 2^36.
- R2: When `exec` and `clr_limit` are both low, `acc_q` and `flags_q` keep their values, whatever the other inputs do.
- R3: A high `rst` at a rising edge clears `acc_q` and `flags_q` to zero, and it takes priority over `exec`.
- R4: Flag bit 3 (negative) equals bit 35 of the new result.
- R5: Flag bit 2 (zero) is set exactly when all 36 result bits are zero.
- R6: Flag bit 0 (carry) is set when the unsigned accumulator is smaller than the unsigned 36-bit extended source plus the carry in, meaning a borrow leaves bit 35.
- R7: Flag bit 1 (overflow) is set when the true signed difference lies outside the range -2^35 to 2^35-1.
- R8: Flag bit 5 (extension in use) is set when result bits 35 down to 31 are not all equal.
- R9: Flag bit 4 (unnormalized) is set when result bits 31 and 30 are equal.
- R10: On an executed step, flag bit 6 (limit) becomes the overflow flag ORed with `flags_in[6]`. The `flags_in[6]` term is dropped when `clr_limit` is high. When `clr_limit` is high with `exec` low, only bit 6 of `flags_q` is cleared.
- R11: The result is not saturated on overflow. It holds the wrapped 36-bit difference. Flag input bits 1 to 5 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| exec | input | 1 | Execute strobe for one subtraction step |
| clr_limit | input | 1 | Clears the sticky limit flag |
| acc_in | input | 36 | Accumulator operand |
| src | input | 32 | Source operand, sign-extended internally |
| flags_in | input | 7 | Current flags; bit 0 is the carry in and bit 6 the prior limit |
| acc_q | output | 36 | Registered result |
| flags_q | output | 7 | Registered flags {L,E,U,N,Z,V,C}, carry at bit 0 |

## Verification
Two situations are hard to reach at random from the ports. The first is the case where overflow and a wrapped result appear together with a carry in that pushes the accumulator across the signed limit, such as the most negative accumulator minus zero minus one. The second is the boundary where the guard bits just stop being pure sign extension. The sweep crosses a fixed set of edge accumulators (signed extremes, values on either side of the 32-bit range, and all-ones) with edge sources and both carry values. Pseudo-random pairs are added to this sweep. The bench computes each expected result with wide signed arithmetic.

// File: rtl/acc_sub_borrow.sv
module acc_sub_borrow #(
  parameter int WORD_W  = 32,
  parameter int GUARD_W = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       exec,
  input  logic                       clr_limit,
  input  logic [WORD_W+GUARD_W-1:0]  acc_in,
  input  logic [WORD_W-1:0]          src,
  input  logic [6:0]                 flags_in,
  output logic [WORD_W+GUARD_W-1:0]  acc_q,
  output logic [6:0]                 flags_q
);
  localparam int AW = WORD_W + GUARD_W;
  localparam int FC = 0, FV = 1, FZ = 2, FN = 3, FU = 4, FE = 5, FL = 6;

  logic [AW-1:0]     src_x;
  logic [AW:0]       diff;
  logic [AW-1:0]     res;
  logic [GUARD_W:0]  ext_seg;
  logic              ovf, ext_use, unnorm, lim_next;
  logic [6:0]        flags_next;

  assign src_x   = {{GUARD_W{src[WORD_W-1]}}, src};
  assign diff    = {1'b0, acc_in} - {1'b0, src_x} - (AW+1)'(flags_in[FC]);
  assign res     = diff[AW-1:0];
  assign ovf     = (acc_in[AW-1] ^ src_x[AW-1]) & (res[AW-1] ^ acc_in[AW-1]);
  assign ext_seg = res[AW-1:WORD_W-1];
  assign ext_use = ~((&ext_seg) | ~(|ext_seg));
  assign unnorm  = res[WORD_W-1] ~^ res[WORD_W-2];
  assign lim_next = (flags_in[FL] & ~clr_limit) | ovf;

  always_comb begin
    flags_next     = '0;
    flags_next[FC] = diff[AW];
    flags_next[FV] = ovf;
    flags_next[FZ] = ~|res;
    flags_next[FN] = res[AW-1];
    flags_next[FU] = unnorm;
    flags_next[FE] = ext_use;
    flags_next[FL] = lim_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      flags_q <= '0;
    end else if (exec) begin
      acc_q   <= res;
      flags_q <= flags_next;
    end else if (clr_limit) begin
      flags_q[FL] <= 1'b0;
    end
  end
endmodule

// File: rtl/chk_acc_sub_borrow.sv
module chk_acc_sub_borrow #(
  parameter int WORD_W  = 32,
  parameter int GUARD_W = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       exec,
  input logic                       clr_limit,
  input logic [WORD_W+GUARD_W-1:0]  acc_in,
  input logic [WORD_W-1:0]          src,
  input logic [6:0]                 flags_in,
  input logic [WORD_W+GUARD_W-1:0]  acc_q,
  input logic [6:0]                 flags_q
);
  localparam int AW = WORD_W + GUARD_W;
  logic [AW-1:0] src_x;
  assign src_x = {{GUARD_W{src[WORD_W-1]}}, src};

  assert_reset_clears_R3: assert property (@(posedge clk)
    rst |=> (acc_q == '0 && flags_q == '0));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!exec && !clr_limit) |=> ($stable(acc_q) && $stable(flags_q)));

  assert_diff_R1: assert property (@(posedge clk) disable iff (rst)
    exec |=> (AW'(acc_q + $past(src_x) + AW'($past(flags_in[0]))) == $past(acc_in)));

  assert_negative_R4: assert property (@(posedge clk) disable iff (rst)
    exec |=> (flags_q[3] == acc_q[AW-1]));

  assert_zero_R5: assert property (@(posedge clk) disable iff (rst)
    exec |=> (flags_q[2] == (acc_q == '0)));

  assert_sticky_limit_R10: assert property (@(posedge clk) disable iff (rst)
    (exec && !clr_limit && flags_in[6]) |=> flags_q[6]);

  assert_limit_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (!exec && clr_limit) |=> (!flags_q[6] && $stable(acc_q) && $stable(flags_q[5:0])));
endmodule

bind acc_sub_borrow chk_acc_sub_borrow #(.WORD_W(WORD_W), .GUARD_W(GUARD_W)) u_chk (
  .clk(clk), .rst(rst), .exec(exec), .clr_limit(clr_limit), .acc_in(acc_in),
  .src(src), .flags_in(flags_in), .acc_q(acc_q), .flags_q(flags_q));

// File: tb/test_acc_sub_borrow.sv
module test_acc_sub_borrow;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst, exec, clr_limit;
  logic [35:0] acc_in, acc_q;
  logic [31:0] src;
  logic [6:0]  flags_in, flags_q;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  acc_sub_borrow i_acc_sub_borrow (
    .clk(clk), .rst(rst), .exec(exec), .clr_limit(clr_limit), .acc_in(acc_in),
    .src(src), .flags_in(flags_in), .acc_q(acc_q), .flags_q(flags_q));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] next_rng();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 7);
    rng = rng ^ (rng << 17);
    return rng;
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one executed step and compare all outputs with arithmetic expectations.
  task automatic run_op(logic [35:0] a, logic [31:0] s, logic c, logic l_in,
                        logic clr, logic [4:0] junk);
    longint a_s, s_s, r, u_src;
    logic [35:0] e_acc;
    logic e_v, e_c, e_l;
    @(negedge clk);
    acc_in = a; src = s; clr_limit = clr; exec = 1'b1;
    flags_in = {l_in, junk, c};
    a_s = a[35] ? longint'(a) - (64'sd1 <<< 36) : longint'(a);
    s_s = s[31] ? longint'(s) - (64'sd1 <<< 32) : longint'(s);
    r = a_s - s_s - longint'(c);
    e_acc = r[35:0];
    e_v = (r > ((64'sd1 <<< 35) - 1)) || (r < -(64'sd1 <<< 35));
    u_src = s_s & ((64'sd1 <<< 36) - 1);
    e_c = longint'(a) < (u_src + longint'(c));
    e_l = (l_in & ~clr) | e_v;
    @(negedge clk);
    exec = 1'b0; clr_limit = 1'b0;
    check("R1 R11 result", acc_q, e_acc);
    check("R6 carry", flags_q[0], e_c);
    check("R7 overflow", flags_q[1], e_v);
    check("R5 zero", flags_q[2], e_acc == 0);
    check("R4 negative", flags_q[3], e_acc[35]);
    check("R9 unnormalized", flags_q[4], e_acc[31] == e_acc[30]);
    check("R8 extension", flags_q[5], !(e_acc[35:31] == 5'h1f || e_acc[35:31] == 5'h00));
    check("R10 limit", flags_q[6], e_l);
  endtask

  function automatic logic [35:0] pick_acc(int i);
    case (i)
      0: return 36'h0_0000_0000;
      1: return 36'h0_0000_0001;
      2: return 36'h7_FFFF_FFFF;
      3: return 36'h8_0000_0000;
      4: return 36'hF_FFFF_FFFF;
      5: return 36'h0_4000_0000;
      6: return 36'h0_7FFF_FFFF;
      7: return 36'hF_8000_0000;
      8: return 36'h0_8000_0000;
      9: return 36'hF_7FFF_FFFF;
      default: return next_rng()[35:0];
    endcase
  endfunction

  function automatic logic [31:0] pick_src(int j);
    case (j)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'h7FFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'hFFFF_FFFF;
      5: return 32'h3FFF_FFFE;
      6: return 32'hC000_0000;
      default: return next_rng()[31:0];
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; exec = 1'b0; clr_limit = 1'b0;
    acc_in = '0; src = '0; flags_in = '0;
    repeat (2) @(negedge clk);
    check("R3 reset acc", acc_q, 0);
    check("R3 reset flags", flags_q, 0);
    rst = 1'b0;

    // Worked example: 0x0_4000_0000 - 0x3FFF_FFFE - 1 = 1, only U set
    run_op(36'h0_4000_0000, 32'h3FFF_FFFE, 1'b1, 1'b0, 1'b0, 5'b0);
    check("R1 example result", acc_q, 36'h0_0000_0001);
    check("R9 example flags", flags_q, 7'b001_0000);

    // Near-exhaustive sweep of edge and random operands, both carry values
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 12; j++)
        for (int c = 0; c < 2; c++)
          run_op(pick_acc(i), pick_src(j), c[0], i[0] ^ j[0], 1'b0, next_rng()[4:0]);

    // R7/R11: most negative minus zero minus carry wraps to most positive
    run_op(36'h8_0000_0000, 32'h0, 1'b1, 1'b0, 1'b0, 5'h1f);
    check("R11 wrap no saturation", acc_q, 36'h7_FFFF_FFFF);
    check("R7 overflow at wrap", flags_q[1], 1);

    // R10: sticky limit kept without overflow, dropped by clear
    run_op(36'h0_0000_0010, 32'h1, 1'b0, 1'b1, 1'b0, 5'b0);
    check("R10 sticky kept", flags_q[6], 1);
    run_op(36'h0_0000_0010, 32'h1, 1'b0, 1'b1, 1'b1, 5'b0);
    check("R10 clear with exec", flags_q[6], 0);

    // R10: clear without exec touches only the limit bit
    run_op(36'h8_0000_0000, 32'h1, 1'b0, 1'b0, 1'b0, 5'b0);
    begin
      logic [35:0] keep_acc;
      logic [6:0]  keep_fl;
      keep_acc = acc_q; keep_fl = flags_q;
      check("R10 limit set before clear", keep_fl[6], 1);
      clr_limit = 1'b1;
      @(negedge clk);
      clr_limit = 1'b0;
      check("R10 clear alone limit", flags_q[6], 0);
      check("R10 clear alone acc", acc_q, keep_acc);
      check("R10 clear alone other flags", flags_q[5:0], keep_fl[5:0]);

      // R2: idle with changing inputs holds state
      keep_acc = acc_q; keep_fl = flags_q;
      for (int k = 0; k < 4; k++) begin
        acc_in = next_rng()[35:0]; src = next_rng()[31:0]; flags_in = next_rng()[6:0];
        @(negedge clk);
      end
      check("R2 hold acc", acc_q, keep_acc);
      check("R2 hold flags", flags_q, keep_fl);
    end

    // R3: reset wins over exec
    acc_in = 36'h1_2345_6789; src = 32'h0; flags_in = 7'h40; exec = 1'b1; rst = 1'b1;
    @(negedge clk);
    exec = 1'b0; rst = 1'b0;
    check("R3 reset over exec acc", acc_q, 0);
    check("R3 reset over exec flags", flags_q, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule